// File: doc/BRIEF.md
# Resizable BAR capability and decoder

This block holds the extended-capability registers for one resizable memory BAR and the address decoder that the BAR drives. A configuration agent reads and writes dwords by byte offset through a simple request port. It can read a fixed header and a read-only bitmap of the window sizes the device supports. It selects one of those sizes through a size field in the control register. It also programs the 64-bit BAR base. Read data returns one cycle after the request.

The selected size code k sets the window to 2^(k+20) bytes. Base bits below bit k+20 cannot be written and always read as zero. When the size changes, those bits are cleared on the same clock edge, so the base stays aligned to the window. The decoder compares the upper bits of each incoming 64-bit memory address with the base and raises a hit when the address falls inside the window.

Register map by byte offset: 0x00 header, 0x04 supported sizes, 0x08 control, 0x0C base bits 31:0, 0x10 base bits 63:32. Address bits 1:0 of the offset are ignored.

Top module: `rbar_unit`

## Requirements
- R1: Offset 0x00 reads {NEXT_PTR[11:0], 4'h1, 16'h0015}: capability ID 0x0015 in bits 15:0, version 1 in bits 19:16, next pointer in bits 31:20. Writes to this offset have no effect.
- R2: Offset 0x04 reads SIZE_MASK in bits 23:4, where bit k+4 advertises size code k. Bits 3:0 and 31:24 read zero, and writes to this offset are ignored.
- R3: Offset 0x08 reads the size code in bits 12:8, the constant 1 (number of resizable BARs) in bits 7:5, and BAR_INDEX in bits 2:0. All other bits read zero.
- R4: After reset the size code equals the lowest code advertised in SIZE_MASK, and the base reads zero.
- R5: A control write updates the size code from write data bits 12:8 only when that code is advertised. An unadvertised code, including any code of 20 or above, leaves the size code unchanged. All other written control bits are ignored.
- R6: Offset 0x0C reads base bits 31:4 with 4'b1100 in bits 3:0. Offset 0x10 reads base bits 63:32. Written bits below bit k+20 are dropped and read as zero.
- R7: A size change clears every base bit below the new boundary k+20 on the same edge that stores the new code.
- R8: mem_hit is a combinational output. It is high exactly when mem_valid is high and mem_addr[63:k+20] equals base[63:k+20].
- R9: A read request gives cfg_rvalid high for one cycle on the following cycle, together with the register data. An offset that matches no register reads zero, and a write to such an offset changes nothing.
- R10: While reset is held, cfg_rvalid and cfg_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration request strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_off | input | OFF_W | Byte offset within the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cfg_rdata | output | 32 | Read data |
| mem_valid | input | 1 | Incoming memory address is valid |
| mem_addr | input | 64 | Incoming memory address |
| mem_hit | output | 1 | Address falls inside the BAR window |

## Verification
The hardest case to reach is a size change while high base bits are already set. Such a change must clear exactly the base bits between the old and the new boundary, and it must move the hit window accordingly. The stimulus fills the base with ones at a small window and then steps the size code up and back down through several advertised codes, reading the base after each step. Random traffic mixes advertised and unadvertised codes with base writes and probes. Each probe either targets an address just inside or just outside the window edges, or is a fully random address.

// File: rtl/rbar_pkg.sv
package rbar_pkg;

    localparam int CODE_W     = 5;
    localparam int NUM_CODES  = 20;
    localparam int BASE_SHIFT = 20;
    localparam int AW         = 64;
    localparam int DW         = 32;

    localparam logic [15:0] CAP_ID      = 16'h0015;
    localparam logic [3:0]  CAP_VERSION = 4'h1;
    localparam logic [3:0]  BAR_TYPE    = 4'b1100;
    localparam logic [2:0]  NUM_RBARS   = 3'd1;

    localparam int CTRL_SIZE_LSB = 8;
    localparam int CAP_MAP_LSB   = 4;

    typedef enum logic [2:0] {
        SEL_HDR,
        SEL_CAP,
        SEL_CTRL,
        SEL_BASE_LO,
        SEL_BASE_HI,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic           valid;
        logic           we;
        reg_sel_e       sel;
        logic [DW-1:0]  data;
    } cfg_op_t;

    function automatic reg_sel_e decode_dword(input logic [31:0] idx);
        reg_sel_e s;
        case (idx)
            32'd0:   s = SEL_HDR;
            32'd1:   s = SEL_CAP;
            32'd2:   s = SEL_CTRL;
            32'd3:   s = SEL_BASE_LO;
            32'd4:   s = SEL_BASE_HI;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [AW-1:0] win_mask(input logic [CODE_W-1:0] code);
        return {AW{1'b1}} << (BASE_SHIFT + int'(code));
    endfunction

    function automatic logic [CODE_W-1:0] lowest_code(input logic [NUM_CODES-1:0] m);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = NUM_CODES - 1; i >= 0; i--) begin
            if (m[i]) r = CODE_W'(i);
        end
        return r;
    endfunction

    function automatic logic code_ok(input logic [NUM_CODES-1:0] m,
                                     input logic [CODE_W-1:0] c);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (int'(c) == i) ok = m[i];
        end
        return ok;
    endfunction

endpackage

// File: rtl/rbar_size_ctrl.sv
module rbar_size_ctrl
    import rbar_pkg::*;
#(
    parameter logic [NUM_CODES-1:0] SIZE_MASK = 20'h04554
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CODE_W-1:0] wr_code,
    output logic [CODE_W-1:0] code_q,
    output logic              size_wr,
    output logic [CODE_W-1:0] size_new
);

    localparam logic [CODE_W-1:0] RESET_CODE = lowest_code(SIZE_MASK);

    logic wr_legal;

    always_comb begin
        wr_legal = code_ok(SIZE_MASK, wr_code);
        size_new = wr_code;
        size_wr  = ctrl_wr && wr_legal && (wr_code != code_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (size_wr) begin
            code_q <= size_new;
        end
    end

    // R5: the stored code is always one the bitmap advertises
    assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
        code_ok(SIZE_MASK, code_q));

    // R5: a write carrying an unadvertised code leaves the code alone
    assert_bad_code_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !code_ok(SIZE_MASK, wr_code)) |=> $stable(code_q));

endmodule

// File: rtl/rbar_base_reg.sv
module rbar_base_reg
    import rbar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DW-1:0]     wdata,
    input  logic [CODE_W-1:0] code_q,
    input  logic              size_wr,
    input  logic [CODE_W-1:0] size_new,
    output logic [AW-1:0]     base_q,
    output logic [AW-1:0]     mask
);

    assign mask = win_mask(code_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (size_wr) begin
            base_q <= base_q & win_mask(size_new);
        end else if (wr_lo) begin
            base_q[DW-1:0] <= wdata & mask[DW-1:0];
        end else if (wr_hi) begin
            base_q[AW-1:DW] <= wdata & mask[AW-1:DW];
        end
    end

    // R6: no base bit below the window boundary is ever set
    assert_base_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        ((base_q & ~mask) == '0));

    // R7: after a size change the base is aligned to the new window
    assert_size_clear_R7: assert property (@(posedge clk) disable iff (rst)
        size_wr |=> ((base_q & ~win_mask($past(size_new))) == '0));

endmodule

// File: rtl/rbar_hit_decode.sv
module rbar_hit_decode
    import rbar_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_addr,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] mask,
    output logic          mem_hit
);

    logic [AW-1:0] bit_match;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_match[i] = ~mask[i] | (mem_addr[i] == base_q[i]);
    end

    assign mem_hit = mem_valid & (&bit_match);

    // R8: a hit is only reported for a valid address
    assert_hit_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> mem_valid);

    // R8: a hit address shares the top address bit with the base
    assert_hit_top_bit_R8: assert property (@(posedge clk) disable iff (rst)
        mem_hit |-> (mem_addr[AW-1] == base_q[AW-1]));

endmodule

// File: rtl/rbar_read_port.sv
module rbar_read_port
    import rbar_pkg::*;
#(
    parameter logic [NUM_CODES-1:0] SIZE_MASK = 20'h04554,
    parameter logic [11:0]          NEXT_PTR  = 12'h000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  reg_sel_e      rd_sel,
    input  logic [DW-1:0] ctrl_word,
    input  logic [AW-1:0] base_q,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    localparam logic [DW-1:0] HDR_WORD = {NEXT_PTR, CAP_VERSION, CAP_ID};
    localparam logic [DW-1:0] CAP_WORD = DW'({SIZE_MASK, 4'b0000});

    logic [DW-1:0] rd_mux;

    always_comb begin
        case (rd_sel)
            SEL_HDR:     rd_mux = HDR_WORD;
            SEL_CAP:     rd_mux = CAP_WORD;
            SEL_CTRL:    rd_mux = ctrl_word;
            SEL_BASE_LO: rd_mux = {base_q[DW-1:4], BAR_TYPE};
            SEL_BASE_HI: rd_mux = base_q[AW-1:DW];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_mux : '0;
        end
    end

    // R9: every read request is answered on the next cycle
    assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);

    // R9: no response appears without a request one cycle earlier
    assert_rvalid_only_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);

    // R9: an unmapped offset reads zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/rbar_unit.sv
module rbar_unit
    import rbar_pkg::*;
#(
    parameter logic [NUM_CODES-1:0] SIZE_MASK = 20'h04554,
    parameter logic [2:0]           BAR_INDEX = 3'd0,
    parameter logic [11:0]          NEXT_PTR  = 12'h000,
    parameter int                   OFF_W     = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_req,
    input  logic             cfg_we,
    input  logic [OFF_W-1:0] cfg_off,
    input  logic [31:0]      cfg_wdata,
    output logic             cfg_rvalid,
    output logic [31:0]      cfg_rdata,
    input  logic             mem_valid,
    input  logic [63:0]      mem_addr,
    output logic             mem_hit
);

    localparam int PAD_W = 32 - OFF_W;

    cfg_op_t           op;
    logic [CODE_W-1:0] code_q;
    logic              size_wr;
    logic [CODE_W-1:0] size_new;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     mask;
    logic [DW-1:0]     ctrl_word;
    logic              wr_ctrl;
    logic              wr_lo;
    logic              wr_hi;
    logic              rd_en;

    always_comb begin
        op.valid = cfg_req;
        op.we    = cfg_we;
        op.sel   = decode_dword({{PAD_W{1'b0}}, cfg_off} >> 2);
        op.data  = cfg_wdata;
    end

    assign wr_ctrl = op.valid && op.we && (op.sel == SEL_CTRL);
    assign wr_lo   = op.valid && op.we && (op.sel == SEL_BASE_LO);
    assign wr_hi   = op.valid && op.we && (op.sel == SEL_BASE_HI);
    assign rd_en   = op.valid && !op.we;

    assign ctrl_word = {19'd0, code_q, NUM_RBARS, 2'b00, BAR_INDEX};

    rbar_size_ctrl #(
        .SIZE_MASK (SIZE_MASK)
    ) i_size (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (wr_ctrl),
        .wr_code  (op.data[CTRL_SIZE_LSB +: CODE_W]),
        .code_q   (code_q),
        .size_wr  (size_wr),
        .size_new (size_new)
    );

    rbar_base_reg i_base (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (op.data),
        .code_q   (code_q),
        .size_wr  (size_wr),
        .size_new (size_new),
        .base_q   (base_q),
        .mask     (mask)
    );

    rbar_hit_decode i_hit (
        .clk       (clk),
        .rst       (rst),
        .mem_valid (mem_valid),
        .mem_addr  (mem_addr),
        .base_q    (base_q),
        .mask      (mask),
        .mem_hit   (mem_hit)
    );

    rbar_read_port #(
        .SIZE_MASK (SIZE_MASK),
        .NEXT_PTR  (NEXT_PTR)
    ) i_read (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_sel    (op.sel),
        .ctrl_word (ctrl_word),
        .base_q    (base_q),
        .rvalid    (cfg_rvalid),
        .rdata     (cfg_rdata)
    );

    // R10: while reset is applied the read port stays quiet (checked after the edge)
    always_ff @(posedge clk) begin
        if ($past(rst) && rst) begin
            assert_reset_quiet_R10: assert (!cfg_rvalid && cfg_rdata == '0);
        end
    end

endmodule

// File: tb/test_rbar_unit.sv
module test_rbar_unit;

    localparam logic [19:0] MASK    = 20'h04554;
    localparam logic [2:0]  IDX     = 3'd0;
    localparam logic [11:0] NXT     = 12'h000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_off = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_addr = '0;
    logic        mem_hit;

    int checks = 0;
    int errors = 0;

    logic [4:0]  m_code;
    logic [63:0] m_base;

    always #10 clk = ~clk;

    rbar_unit #(
        .SIZE_MASK (MASK),
        .BAR_INDEX (IDX),
        .NEXT_PTR  (NXT),
        .OFF_W     (12)
    ) i_rbar_unit (
        .clk        (clk),
        .rst        (rst),
        .cfg_req    (cfg_req),
        .cfg_we     (cfg_we),
        .cfg_off    (cfg_off),
        .cfg_wdata  (cfg_wdata),
        .cfg_rvalid (cfg_rvalid),
        .cfg_rdata  (cfg_rdata),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_hit    (mem_hit)
    );

    function automatic logic [63:0] mwin(input logic [4:0] c);
        return ~64'd0 << (20 + int'(c));
    endfunction

    function automatic bit adv(input logic [4:0] c);
        return (c < 5'd20) && (((MASK >> c) & 20'd1) != 0);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] off);
        case (off >> 2)
            12'd0:   return {NXT, 4'h1, 16'h0015};
            12'd1:   return {8'h00, MASK, 4'h0};
            12'd2:   return {19'd0, m_code, 3'd1, 2'b00, IDX};
            12'd3:   return {m_base[31:4], 4'b1100};
            12'd4:   return m_base[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] off);
        case (off >> 2)
            12'd0:   return "R1";
            12'd1:   return "R2";
            12'd2:   return "R3";
            12'd3:   return "R6";
            12'd4:   return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b1; cfg_off = off; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0; cfg_we = 1'b0;
        case (off >> 2)
            12'd2: if (adv(d[12:8])) begin
                m_code = d[12:8];
                m_base = m_base & mwin(m_code);
            end
            12'd3: m_base[31:0]  = d & mwin(m_code) & 32'hFFFF_FFFF;
            12'd4: m_base[63:32] = d & mwin(m_code) >> 32;
            default: ;
        endcase
    endtask

    task automatic cfg_check(input logic [11:0] off, input string req);
        logic [31:0] e;
        e = exp_rd(off);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = 1'b0; cfg_off = off;
        @(negedge clk);
        cfg_req = 1'b0;
        check("R9", {63'd0, cfg_rvalid}, 64'd1);
        check(req, {32'd0, cfg_rdata}, {32'd0, e});
        @(negedge clk);
        check("R9", {63'd0, cfg_rvalid}, 64'd0);
    endtask

    task automatic probe(input logic v, input logic [63:0] a);
        logic e;
        @(negedge clk);
        mem_valid = v; mem_addr = a;
        #1;
        e = v && (((a ^ m_base) & mwin(m_code)) == 64'd0);
        check("R8", {63'd0, mem_hit}, {63'd0, e});
        mem_valid = 1'b0;
    endtask

    task automatic edge_probes();
        logic [63:0] sz;
        sz = 64'd1 << (20 + int'(m_code));
        probe(1'b1, m_base);
        probe(1'b1, m_base + sz - 64'd1);
        probe(1'b1, m_base + sz);
        probe(1'b1, m_base - 64'd1);
        probe(1'b0, m_base);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [4:0] codes [8];
        void'($urandom(32'd2024));
        m_code = 5'd2;
        m_base = '0;
        repeat (3) @(negedge clk);
        // R10: quiet during reset
        check("R10", {63'd0, cfg_rvalid}, 64'd0);
        check("R10", {32'd0, cfg_rdata}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        cfg_check(12'h008, "R4");
        cfg_check(12'h00C, "R4");
        cfg_check(12'h010, "R4");
        cfg_check(12'h000, "R1");
        cfg_check(12'h004, "R2");
        cfg_check(12'h014, "R9");
        cfg_check(12'h3FC, "R9");

        // R1 R2: read-only words ignore writes
        cfg_write(12'h000, 32'hFFFF_FFFF);
        cfg_check(12'h000, "R1");
        cfg_write(12'h004, 32'hFFFF_FFFF);
        cfg_check(12'h004, "R2");
        // R9: write to unmapped offset changes nothing
        cfg_write(12'h018, 32'hFFFF_FFFF);
        for (int o = 0; o < 5; o++) cfg_check(12'(o * 4), "R9");

        // R5: unadvertised codes and other control bits
        cfg_write(12'h008, 32'hFFFF_E0FF & {19'h7FFFF, 5'd3, 8'hFF});
        cfg_check(12'h008, "R5");
        cfg_write(12'h008, {19'd0, 5'd20, 8'hFF});
        cfg_check(12'h008, "R5");
        cfg_write(12'h008, {19'h7FFFF, 5'd31, 8'hFF});
        cfg_check(12'h008, "R5");
        cfg_write(12'h008, {19'h7FFFF, 5'd8, 8'hFF});
        cfg_check(12'h008, "R5");

        // R6 R7: fill base at small window, then step sizes
        cfg_write(12'h008, {19'd0, 5'd2, 8'd0});
        cfg_write(12'h00C, 32'hFFFF_FFFF);
        cfg_write(12'h010, 32'hFFFF_FFFF);
        cfg_check(12'h00C, "R6");
        cfg_check(12'h010, "R6");
        edge_probes();
        codes = '{5'd10, 5'd14, 5'd19, 5'd4, 5'd14, 5'd6, 5'd2, 5'd8};
        foreach (codes[i]) begin
            cfg_write(12'h008, {19'd0, codes[i], 8'd0});
            cfg_check(12'h00C, "R7");
            cfg_check(12'h010, "R7");
            cfg_check(12'h008, "R5");
            edge_probes();
            cfg_write(12'h010, $urandom);
            cfg_write(12'h00C, $urandom);
            edge_probes();
        end

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int unsigned kind;
            kind = $urandom_range(0, 5);
            case (kind)
                0: cfg_write(12'h008, {$urandom} & 32'hFFFF_E0FF |
                        ({27'd0, 5'($urandom_range(0, 31))} << 8));
                1: cfg_write(12'h00C, $urandom);
                2: cfg_write(12'h010, $urandom);
                3: begin
                    logic [11:0] o;
                    o = 12'($urandom_range(0, 15) * 4);
                    cfg_check(o, req_of(o));
                end
                4: probe(1'($urandom), m_base | ({$urandom, $urandom} & ~mwin(m_code)));
                default: probe(1'b1, {$urandom, $urandom});
            endcase
        end
        edge_probes();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule